// File: doc/BRIEF.md
# Auto-Ranging Shunt Amplifier Gain Controller

This block picks the gain of the programmable amplifier in front of a current-shunt converter. Each new signed sample is compared, by magnitude and referred back to the shunt input, with limits that belong to the gain in force. A small signal moves the gain up one step. A signal that nears the top of the range moves it down one step. The up and down limits of each step are set apart, so that a signal sitting near a limit does not make the gain flip back and forth. A sample beyond the clipping half-range of its gain is flagged as saturated.

The gain has four settings, 4, 16, 64 and 256. Samples arrive as signed codes of 0.6 µV per LSB with a valid strobe. Each accepted sample is passed on one cycle later, together with the gain that was in force when it was taken and its saturation flag. Whenever the channel is enabled, the block restarts at gain 4 and holds for an auto-zero settling time of 200 µs. The time is counted in clock cycles, derived from the clock frequency and the interval given as parameters. During that time, samples are ignored.

Top module: `pga_autorange`

## Requirements
- R1: `gain_sel` and `out_gain` encode the gain as 0=x4, 1=x16, 2=x64, 3=x256. After reset, `gain_sel` is 0 and `out_valid` is 0.
- R2: An accepted sample whose magnitude is below the step-up limit of the current gain raises the gain by one step. The limits are 62500 codes at x4, 15625 at x16 and 3906 at x64. There is no step up from x256.
- R3: An accepted sample whose magnitude is above the step-down limit of the current gain lowers the gain by one step. The limits are 114583 codes at x16, 28646 at x64 and 7163 at x256. There is no step down from x4. A magnitude exactly equal to a limit causes no step.
- R4: `out_sat` is 1 when the magnitude is above the clipping half-range of the gain in force. The half-ranges are 250000 codes at x4, 130166 at x16, 32500 at x64 and 8166 at x256. A saturated sample at a gain above x4 always lowers the gain by exactly one step.
- R5: The gain moves by at most one step per accepted sample. A magnitude between the two limits of a step leaves the gain unchanged. The gain never changes without an accepted sample.
- R6: One cycle after an accepted sample, `out_valid` pulses for one cycle. `out_code` then carries the sample, and `out_gain` carries the gain that was in force before the sample's own decision.
- R7: While `chan_en` is 0, the gain is x4 and no sample is accepted. After `chan_en` rises, the first AZ_CYCLES clock cycles form an auto-zero hold, in which samples are ignored and the gain does not move.
- R8: The decisions use the magnitude, so a negative code behaves exactly like the positive code of the same size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_en | input | 1 | Channel enable; a rising edge starts the auto-zero hold |
| in_valid | input | 1 | Sample strobe |
| in_code | input | CODE_W | Signed sample, 0.6 µV per LSB at the shunt |
| gain_sel | output | 2 | Gain in force, driven to the amplifier |
| out_valid | output | 1 | Output sample strobe |
| out_code | output | CODE_W | Forwarded sample |
| out_gain | output | 2 | Gain in force when the sample was taken |
| out_sat | output | 1 | Sample beyond the clipping half-range |

## Verification
The assertions rely on `in_code` being held at a value that is not the most negative code. They also rely on the auto-zero interval being at least one cycle. The stimulus draws codes in a symmetric window of ±300000 codes. It aims many draws at a few codes on either side of the limits of the current gain, and it holds `chan_en` steady except at a few directed enable and disable points. Saturated and beyond-range samples are included on purpose, so that the forced step down is exercised at every gain.

// File: rtl/pga_pkg.sv
package pga_pkg;
  typedef enum logic [1:0] {GAIN_X4 = 2'd0, GAIN_X16 = 2'd1, GAIN_X64 = 2'd2, GAIN_X256 = 2'd3} gain_e;

  localparam int NUM_STEPS = 4;

  // Limits in nanovolts at the shunt input, per gain index.
  function automatic int up_limit_nv(input int idx);
    case (idx)
      0: return 37_500_000;
      1: return 9_375_000;
      2: return 2_344_000;
      default: return 0;
    endcase
  endfunction

  function automatic int down_limit_nv(input int idx);
    case (idx)
      1: return 68_750_000;
      2: return 17_188_000;
      3: return 4_298_000;
      default: return 0;
    endcase
  endfunction

  function automatic int clip_limit_nv(input int idx);
    case (idx)
      0: return 150_000_000;
      1: return 78_100_000;
      2: return 19_500_000;
      default: return 4_900_000;
    endcase
  endfunction
endpackage

// File: rtl/pga_az_timer.sv
module pga_az_timer #(
  parameter int AZ_CYCLES = 25000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic chan_en,
  output logic accept_ok
);
  localparam int CNT_W = $clog2(AZ_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(AZ_CYCLES);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (!chan_en) begin
      cnt_en = (cnt_q != LOAD);
      cnt_d  = LOAD;
    end else if (cnt_q != '0) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= LOAD;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign accept_ok = chan_en && (cnt_q == '0);

  // R7: acceptance opens only after the channel was enabled in the previous cycle too
  assert_holdoff_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(accept_ok) |-> (chan_en && $past(chan_en)));
endmodule

// File: rtl/pga_range_eval.sv
module pga_range_eval #(
  parameter int CODE_W = 20,
  parameter int LSB_NV = 600
) (
  input  logic              [1:0]        gain,
  input  logic signed       [CODE_W-1:0] code,
  output logic                           want_up,
  output logic                           want_down,
  output logic                           clipped
);
  localparam int MAG_W = CODE_W + 1;
  localparam int NS    = pga_pkg::NUM_STEPS;

  logic [MAG_W-1:0] mag;
  logic [NS-1:0]    up_vec, dn_vec, clip_vec;

  always_comb begin
    if (code[CODE_W-1]) mag = MAG_W'(-$signed({code[CODE_W-1], code}));
    else                mag = MAG_W'(code);
  end

  for (genvar g = 0; g < NS; g++) begin : g_step
    localparam logic [MAG_W-1:0] UP_T   = MAG_W'(pga_pkg::up_limit_nv(g) / LSB_NV);
    localparam logic [MAG_W-1:0] DN_T   = MAG_W'(pga_pkg::down_limit_nv(g) / LSB_NV);
    localparam logic [MAG_W-1:0] CLIP_T = MAG_W'(pga_pkg::clip_limit_nv(g) / LSB_NV);
    assign clip_vec[g] = (mag > CLIP_T);
    if (g < NS - 1) begin : g_up
      assign up_vec[g] = (mag < UP_T);
    end else begin : g_top
      assign up_vec[g] = 1'b0;
    end
    if (g > 0) begin : g_dn
      assign dn_vec[g] = (mag > DN_T) || clip_vec[g];
    end else begin : g_bottom
      assign dn_vec[g] = 1'b0;
    end
  end

  assign want_up   = up_vec[gain];
  assign want_down = dn_vec[gain];
  assign clipped   = clip_vec[gain];

  // R3: the two step directions never both fire
  always_comb begin
    assert_no_conflict_R3: assert (!(want_up && want_down));
  end
endmodule

// File: rtl/pga_step_reg.sv
module pga_step_reg #(
  parameter int CODE_W = 20
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     restart,
  input  logic                     take,
  input  logic signed [CODE_W-1:0] code,
  input  logic                     want_up,
  input  logic                     want_down,
  input  logic                     clipped,
  output logic        [1:0]        gain,
  output logic                     out_valid,
  output logic signed [CODE_W-1:0] out_code,
  output logic        [1:0]        out_gain,
  output logic                     out_sat
);
  import pga_pkg::*;

  gain_e gain_q, gain_d;
  logic  gain_en;
  logic  data_en;

  always_comb begin
    gain_d  = gain_q;
    gain_en = 1'b0;
    if (restart) begin
      gain_d  = GAIN_X4;
      gain_en = (gain_q != GAIN_X4);
    end else if (take) begin
      if (want_down)    gain_d = gain_e'(gain_q - 2'd1);
      else if (want_up) gain_d = gain_e'(gain_q + 2'd1);
      gain_en = want_down || want_up;
    end
  end

  assign data_en = take && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       gain_q <= GAIN_X4;
    else if (gain_en) gain_q <= gain_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= data_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_code <= '0;
      out_gain <= 2'd0;
      out_sat  <= 1'b0;
    end else if (data_en) begin
      out_code <= code;
      out_gain <= gain_q;
      out_sat  <= clipped;
    end
  end

  assign gain = gain_q;

  // R5: at most one step per cycle
  assert_one_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_q == $past(gain_q)) || (gain_q == $past(gain_q) + 2'd1) ||
    (gain_q == $past(gain_q) - 2'd1) || (gain_q == GAIN_X4));

  // R5: the gain moves only on an accepted sample or a restart
  assert_gain_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !restart) |=> $stable(gain_q));

  // R4: a clipped sample above x4 leaves the gain one step lower
  assert_sat_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_en && clipped && gain_q != GAIN_X4) |=> (gain_q == $past(gain_q) - 2'd1));

  // R6: an output strobe follows an accepted sample
  assert_out_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(data_en));
endmodule

// File: rtl/pga_autorange.sv
module pga_autorange #(
  parameter int CODE_W  = 20,
  parameter int LSB_NV  = 600,
  parameter int CLK_KHZ = 125000,
  parameter int AZ_US   = 200
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     chan_en,
  input  logic                     in_valid,
  input  logic signed [CODE_W-1:0] in_code,
  output logic        [1:0]        gain_sel,
  output logic                     out_valid,
  output logic signed [CODE_W-1:0] out_code,
  output logic        [1:0]        out_gain,
  output logic                     out_sat
);
  localparam int AZ_RAW    = (CLK_KHZ / 1000) * AZ_US;
  localparam int AZ_CYCLES = (AZ_RAW < 1) ? 1 : AZ_RAW;

  logic accept_ok, take, want_up, want_down, clipped;

  pga_az_timer #(.AZ_CYCLES(AZ_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .accept_ok(accept_ok));

  assign take = in_valid && accept_ok;

  pga_range_eval #(.CODE_W(CODE_W), .LSB_NV(LSB_NV)) u_eval (
    .gain(gain_sel), .code(in_code),
    .want_up(want_up), .want_down(want_down), .clipped(clipped));

  pga_step_reg #(.CODE_W(CODE_W)) u_step (
    .clk(clk), .rst_n(rst_n), .restart(!chan_en), .take(take), .code(in_code),
    .want_up(want_up), .want_down(want_down), .clipped(clipped),
    .gain(gain_sel), .out_valid(out_valid), .out_code(out_code),
    .out_gain(out_gain), .out_sat(out_sat));

  // R7: a disabled channel sits at x4 on the next cycle
  assert_start_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |=> (gain_sel == 2'd0));

  // R7: no output while the channel was disabled
  assert_quiet_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |=> !out_valid);

  // R6: the reported gain is the one that was driven when the sample came in
  assert_old_gain_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_gain == $past(gain_sel)));
endmodule

// File: tb/sim_pga_autorange.sv
module sim_pga_autorange;
  localparam int CODE_W = 20;
  localparam int AZ     = 125;

  logic clk = 1'b0;
  logic rst_n, chan_en, in_valid;
  logic signed [CODE_W-1:0] in_code;
  logic [1:0] gain_sel, out_gain;
  logic out_valid, out_sat;
  logic signed [CODE_W-1:0] out_code;

  int total = 0;
  int bad   = 0;
  int g_m   = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  pga_autorange #(.CODE_W(CODE_W), .LSB_NV(600), .CLK_KHZ(125000), .AZ_US(1)) u0 (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .in_valid(in_valid), .in_code(in_code),
    .gain_sel(gain_sel), .out_valid(out_valid), .out_code(out_code),
    .out_gain(out_gain), .out_sat(out_sat));

  function automatic int up_lim(input int g);
    case (g) 0: return 62500; 1: return 15625; 2: return 3906; default: return 0; endcase
  endfunction
  function automatic int dn_lim(input int g);
    case (g) 1: return 114583; 2: return 28646; 3: return 7163; default: return 0; endcase
  endfunction
  function automatic int sat_lim(input int g);
    case (g) 0: return 250000; 1: return 130166; 2: return 32500; default: return 8166; endcase
  endfunction
  function automatic int next_gain(input int g, input int code);
    int m = (code < 0) ? -code : code;
    if (g > 0 && (m > dn_lim(g) || m > sat_lim(g))) return g - 1;
    if (g < 3 && m < up_lim(g)) return g + 1;
    return g;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input int code, input string req);
    int exp_sat, exp_next;
    int m = (code < 0) ? -code : code;
    exp_sat  = (m > sat_lim(g_m)) ? 1 : 0;
    exp_next = next_gain(g_m, code);
    in_valid = 1'b1;
    in_code  = CODE_W'(code);
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " valid"}, int'(out_valid), 1);
    chk({req, " code"}, int'(out_code), code);
    chk({req, " gain"}, int'(out_gain), g_m);
    chk({req, " sat"}, int'(out_sat), exp_sat);
    chk({req, " next"}, int'(gain_sel), exp_next);
    g_m = exp_next;
    @(negedge clk);
    chk({req, " pulse"}, int'(out_valid), 0);
  endtask

  task automatic send_ignored(input int code, input string req);
    in_valid = 1'b1;
    in_code  = CODE_W'(code);
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " no out"}, int'(out_valid), 0);
    chk({req, " gain"}, int'(gain_sel), g_m);
  endtask

  task automatic enable_and_wait();
    chan_en = 1'b1;
    for (int i = 0; i < AZ + 3; i++) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; chan_en = 1'b0; in_valid = 1'b0; in_code = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset gain", int'(gain_sel), 0);
    chk("R1 reset valid", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    send_ignored(0, "R7 disabled");
    chan_en = 1'b1;
    for (int i = 0; i < 5; i++) send_ignored(10, "R7 autozero hold");
    for (int i = 0; i < AZ; i++) @(negedge clk);
    send(0, "R1 R2 up x4");
    send(0, "R2 up x16");
    send(0, "R2 up x64");
    send(0, "R2 no up at x256");
    send(7163, "R3 equal limit x256");
    send(7164, "R3 down x256");
    send(-3905, "R2 R8 negative up x64");
    send(8167, "R4 sat x256");
    send(-32501, "R4 R8 sat x64");
    send(-114584, "R3 R8 down x16");
    send(62500, "R2 equal limit x4");
    send(250001, "R4 sat x4 no down");
    send(-250000, "R4 R8 edge x4");
    send(-62499, "R2 R8 up x4");
    send(114583, "R5 hold between x16");
    send(-200000, "R4 sat x16 one step");
    chan_en = 1'b0;
    @(negedge clk);
    g_m = 0;
    chk("R7 disable to x4", int'(gain_sel), 0);
    send_ignored(0, "R7 disabled sample");
    enable_and_wait();
    for (int n = 0; n < 400; n++) begin
      int sel = int'($urandom_range(0, 5));
      int c;
      case (sel)
        0: c = up_lim(g_m) + int'($urandom_range(0, 6)) - 3;
        1: c = dn_lim(g_m) + int'($urandom_range(0, 6)) - 3;
        2: c = sat_lim(g_m) + int'($urandom_range(0, 6)) - 3;
        3: c = int'($urandom_range(0, 300000));
        default: c = int'($urandom_range(0, 20000));
      endcase
      if ($urandom_range(0, 1) == 1) c = -c;
      send(c, "R5 R8 random");
      if (n == 200) begin
        chan_en = 1'b0;
        @(negedge clk);
        g_m = 0;
        chk("R7 mid disable", int'(gain_sel), 0);
        enable_and_wait();
      end
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule